// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Break Handling and Framing Resynchronisation

This block turns a synchronized serial input line into characters. It counts a 16x oversampling enable to find each bit, accepts a start bit only when it survives to its midpoint, and reads five to eight data bits, least significant bit first. An optional parity bit follows, then the stop bit. Each finished character appears on a registered output bus with its parity-error, framing-error and break flags, and a one-clock strobe marks it. The strobe feeds whatever stores characters downstream.

Two line conditions have their own handling. If the line stays low for longer than a full character time, the block delivers a single all-zero character flagged as a break, however long the low level lasts. It then waits for the line to return high before it looks for a start bit again. When a character ends in a low stop bit but carries data, the block delivers it with a framing error and takes that low bit as the start of the next character. It confirms the low level one tick later and reads the next data bits from there.

Top module: `serial_rx`

## Requirements
- R1: After reset the strobe `rx_valid` is low and `rx_data`, `rx_perr`, `rx_ferr` and `rx_brk` are all zero.
- R2: A low level seen on a tick arms reception only if the line is still low at the 8th tick after it. If the line is high there, no character is produced.
- R3: `cfg_wlen` selects the word length: 0 for 5 bits, 1 for 6, 2 for 7 and 3 for 8. Data bits are sampled 16 ticks apart, least significant first, and the unused upper bits of `rx_data` are zero.
- R4: With `cfg_par_en` high, one parity bit follows the data. `rx_perr` is set when the data bits plus the parity bit hold an odd count of ones while `cfg_par_even` is 1, or an even count while it is 0. With `cfg_par_en` low, `rx_perr` stays 0.
- R5: Only the first stop bit is checked. A low sample there sets `rx_ferr`. `cfg_stop2` does not change where the character ends, so a new start bit may follow the first stop bit directly.
- R6: When the first stop bit is low and some start, data or parity sample was high, the character is delivered with `rx_ferr` set. The low stop bit is then treated as the next start bit: it is confirmed on the next tick, and the data samples of the next character are taken 16, 32 and so on ticks after the stop sample.
- R7: Let the break limit be 16 × (1 + word length + parity bit + stop-bit count). Once the line has been low for more than that many consecutive ticks, exactly one character is delivered, with data 0, `rx_brk`=1, `rx_ferr`=1 and `rx_perr`=0.
- R8: If every sample of a character was low but the line rises before the break limit is passed, one character is delivered with data 0, `rx_ferr`=1 and `rx_brk`=0, and the line returning high starts no new character.
- R9: After a break, no character is produced until the line has returned high and a new start bit has been accepted.
- R10: `rx_valid` is high for exactly one clock, in the cycle after the tick on which the deciding sample is taken. The data and flags hold their values until the next strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | 16x oversampling enable, one clock wide |
| rxd | input | 1 | Synchronized serial input, idle high |
| cfg_wlen | input | 2 | Word length select, 0..3 for 5..8 bits |
| cfg_par_en | input | 1 | Parity bit present |
| cfg_par_even | input | 1 | 1 for even parity, 0 for odd |
| cfg_stop2 | input | 1 | Two stop bits; affects only the break limit |
| rx_data | output | 8 | Received character, LSB aligned |
| rx_perr | output | 1 | Parity error of the delivered character |
| rx_ferr | output | 1 | Framing error of the delivered character |
| rx_brk | output | 1 | Delivered character is a break |
| rx_valid | output | 1 | One-clock strobe for a delivered character |

## Verification
Each result is due one clock after a tick. A good or framing-error character appears after the tick that samples the middle of the first stop bit. A break character appears after the first tick on which the low run exceeds the limit. The zero character of R8 appears after the first high tick. The bench drives the line one tick at a time and records every strobe at the falling clock edge. It reads the record only after the stop bit or the low run has fully ended, so each expected strobe has already happened. Glitch, resync and break cases also check the number of strobes, so an extra or missing character is caught.

// File: rtl/serial_rx_pkg.sv
package serial_rx_pkg;

    typedef enum logic [2:0] {
        RX_IDLE,
        RX_START,
        RX_DATA,
        RX_PAR,
        RX_STOP,
        RX_RESYNC,
        RX_BRKCHK,
        RX_BRKWAIT
    } rx_state_e;

endpackage

// File: rtl/serial_rx_lowrun.sv
// Counts consecutive ticks on which the line was sampled low (saturating).
module serial_rx_lowrun #(
    parameter int LOW_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             rxd,
    output logic [LOW_W-1:0] run_len
);
    localparam logic [LOW_W-1:0] RUN_MAX = {LOW_W{1'b1}};

    logic [LOW_W-1:0] run_d, run_q;

    always_comb begin
        run_d = run_q;
        if (tick) begin
            if (rxd) begin
                run_d = '0;
            end else if (run_q != RUN_MAX) begin
                run_d = run_q + LOW_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q <= '0;
        end else begin
            run_q <= run_d;
        end
    end

    assign run_len = run_q;

    // R7: a high sample ends any low run
    p_run_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && rxd) |=> (run_len == '0));

    // R7: a low sample extends an unsaturated run by one
    p_run_grow_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !rxd && run_len != RUN_MAX) |=> (run_len == $past(run_len) + LOW_W'(1)));

endmodule

// File: rtl/serial_rx_limit.sv
// Break limit in ticks: one full character time for the current format.
module serial_rx_limit #(
    parameter int OVS   = 16,
    parameter int LOW_W = 8
) (
    input  logic [1:0]       cfg_wlen,
    input  logic             cfg_par_en,
    input  logic             cfg_stop2,
    output logic [LOW_W-1:0] limit
);
    logic [LOW_W-1:0] bits_per_char;

    always_comb begin
        // start + (5 + wlen) data + parity + (1 or 2) stop
        bits_per_char = LOW_W'(7) + LOW_W'(cfg_wlen) + LOW_W'(cfg_par_en) + LOW_W'(cfg_stop2);
        limit         = LOW_W'(OVS) * bits_per_char;
    end

endmodule

// File: rtl/serial_rx_parity.sv
// Parity evaluation of a captured character.
module serial_rx_parity #(
    parameter int DATA_W = 8
) (
    input  logic [DATA_W-1:0] data,
    input  logic              pbit,
    input  logic              par_en,
    input  logic              par_even,
    output logic              perr
);
    logic odd_ones;

    always_comb begin
        odd_ones = (^data) ^ pbit;
        perr     = par_en & (odd_ones ^ ~par_even);
    end

endmodule

// File: rtl/serial_rx.sv
module serial_rx
    import serial_rx_pkg::*;
#(
    parameter int OVS    = 16,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              rxd,
    input  logic [1:0]        cfg_wlen,
    input  logic              cfg_par_en,
    input  logic              cfg_par_even,
    input  logic              cfg_stop2,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_perr,
    output logic              rx_ferr,
    output logic              rx_brk,
    output logic              rx_valid
);
    localparam int CNT_W = $clog2(OVS);
    localparam int IDX_W = $clog2(DATA_W);
    localparam int HALF  = OVS / 2;
    localparam int LOW_W = $clog2(OVS * (DATA_W + 4) + 1);

    localparam logic [CNT_W-1:0] MID_CNT  = CNT_W'(HALF - 1);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(OVS - 1);

    typedef struct packed {
        rx_state_e         st;
        logic [CNT_W-1:0]  tcnt;
        logic [IDX_W-1:0]  bidx;
        logic [DATA_W-1:0] shreg;
        logic              pbit;
        logic              anyone;
        logic [DATA_W-1:0] o_data;
        logic              o_perr;
        logic              o_ferr;
        logic              o_brk;
        logic              o_valid;
    } rx_regs_t;

    rx_regs_t rx_d, rx_q;

    logic [LOW_W-1:0] run_len;
    logic [LOW_W-1:0] brk_limit;
    logic             char_perr;
    logic [IDX_W-1:0] last_idx;
    logic             bit_due;

    serial_rx_lowrun #(
        .LOW_W (LOW_W)
    ) u_lowrun (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick),
        .rxd     (rxd),
        .run_len (run_len)
    );

    serial_rx_limit #(
        .OVS   (OVS),
        .LOW_W (LOW_W)
    ) u_limit (
        .cfg_wlen   (cfg_wlen),
        .cfg_par_en (cfg_par_en),
        .cfg_stop2  (cfg_stop2),
        .limit      (brk_limit)
    );

    serial_rx_parity #(
        .DATA_W (DATA_W)
    ) u_parity (
        .data     (rx_q.shreg),
        .pbit     (rx_q.pbit),
        .par_en   (cfg_par_en),
        .par_even (cfg_par_even),
        .perr     (char_perr)
    );

    always_comb begin
        last_idx = IDX_W'(4) + IDX_W'(cfg_wlen);
        bit_due  = (rx_q.tcnt == FULL_CNT);

        rx_d         = rx_q;
        rx_d.o_valid = 1'b0;

        if (tick) begin
            case (rx_q.st)
                RX_IDLE: begin
                    if (!rxd) begin
                        rx_d.st   = RX_START;
                        rx_d.tcnt = '0;
                    end
                end

                RX_START: begin
                    if (rx_q.tcnt == MID_CNT) begin
                        if (rxd) begin
                            rx_d.st = RX_IDLE;
                        end else begin
                            rx_d.st     = RX_DATA;
                            rx_d.tcnt   = '0;
                            rx_d.bidx   = '0;
                            rx_d.shreg  = '0;
                            rx_d.pbit   = 1'b0;
                            rx_d.anyone = 1'b0;
                        end
                    end else begin
                        rx_d.tcnt = rx_q.tcnt + CNT_W'(1);
                    end
                end

                RX_DATA: begin
                    if (bit_due) begin
                        rx_d.tcnt              = '0;
                        rx_d.shreg[rx_q.bidx]  = rxd;
                        rx_d.anyone            = rx_q.anyone | rxd;
                        if (rx_q.bidx == last_idx) begin
                            rx_d.st = cfg_par_en ? RX_PAR : RX_STOP;
                        end else begin
                            rx_d.bidx = rx_q.bidx + IDX_W'(1);
                        end
                    end else begin
                        rx_d.tcnt = rx_q.tcnt + CNT_W'(1);
                    end
                end

                RX_PAR: begin
                    if (bit_due) begin
                        rx_d.tcnt   = '0;
                        rx_d.pbit   = rxd;
                        rx_d.anyone = rx_q.anyone | rxd;
                        rx_d.st     = RX_STOP;
                    end else begin
                        rx_d.tcnt = rx_q.tcnt + CNT_W'(1);
                    end
                end

                RX_STOP: begin
                    if (bit_due) begin
                        rx_d.tcnt = '0;
                        if (rxd) begin
                            rx_d.o_data  = rx_q.shreg;
                            rx_d.o_perr  = char_perr;
                            rx_d.o_ferr  = 1'b0;
                            rx_d.o_brk   = 1'b0;
                            rx_d.o_valid = 1'b1;
                            rx_d.st      = RX_IDLE;
                        end else if (!rx_q.anyone) begin
                            rx_d.st = RX_BRKCHK;
                        end else begin
                            rx_d.o_data  = rx_q.shreg;
                            rx_d.o_perr  = char_perr;
                            rx_d.o_ferr  = 1'b1;
                            rx_d.o_brk   = 1'b0;
                            rx_d.o_valid = 1'b1;
                            rx_d.st      = RX_RESYNC;
                        end
                    end else begin
                        rx_d.tcnt = rx_q.tcnt + CNT_W'(1);
                    end
                end

                RX_RESYNC: begin
                    if (rxd) begin
                        rx_d.st = RX_IDLE;
                    end else begin
                        rx_d.st     = RX_DATA;
                        rx_d.tcnt   = CNT_W'(1);
                        rx_d.bidx   = '0;
                        rx_d.shreg  = '0;
                        rx_d.pbit   = 1'b0;
                        rx_d.anyone = 1'b0;
                    end
                end

                RX_BRKCHK: begin
                    if (rxd) begin
                        rx_d.o_data  = rx_q.shreg;
                        rx_d.o_perr  = char_perr;
                        rx_d.o_ferr  = 1'b1;
                        rx_d.o_brk   = 1'b0;
                        rx_d.o_valid = 1'b1;
                        rx_d.st      = RX_IDLE;
                    end else if (run_len >= brk_limit) begin
                        rx_d.o_data  = '0;
                        rx_d.o_perr  = 1'b0;
                        rx_d.o_ferr  = 1'b1;
                        rx_d.o_brk   = 1'b1;
                        rx_d.o_valid = 1'b1;
                        rx_d.st      = RX_BRKWAIT;
                    end
                end

                RX_BRKWAIT: begin
                    if (rxd) begin
                        rx_d.st = RX_IDLE;
                    end
                end

                default: begin
                    rx_d.st = RX_IDLE;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_q <= '0;
        end else begin
            rx_q <= rx_d;
        end
    end

    assign rx_data  = rx_q.o_data;
    assign rx_perr  = rx_q.o_perr;
    assign rx_ferr  = rx_q.o_ferr;
    assign rx_brk   = rx_q.o_brk;
    assign rx_valid = rx_q.o_valid;

    // R10: the strobe never lasts two clocks
    p_strobe_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid);

    // R10: an idle receiver produces no character on the next clock
    p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_q.st == RX_IDLE) |=> !rx_valid);

    // R7: a break character is all zero with framing set and parity clear
    p_brk_shape_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && rx_brk) |-> (rx_data == '0 && rx_ferr && !rx_perr));

    // R2: a high line at the start midpoint drops back to idle without output
    p_glitch_drop_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_q.st == RX_START && tick && rx_q.tcnt == MID_CNT && rxd)
        |=> (rx_q.st == RX_IDLE && !rx_valid));

    // R9: while the line stays low after a break the receiver stays parked
    p_brk_park_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_q.st == RX_BRKWAIT && (!tick || !rxd)) |=> (rx_q.st == RX_BRKWAIT && !rx_valid));

endmodule

// File: tb/serial_rx_test.sv
module serial_rx_test;

    logic       clk;
    logic       rst_n;
    logic       tick;
    logic       rxd;
    logic [1:0] cfg_wlen;
    logic       cfg_par_en;
    logic       cfg_par_even;
    logic       cfg_stop2;
    logic [7:0] rx_data;
    logic       rx_perr;
    logic       rx_ferr;
    logic       rx_brk;
    logic       rx_valid;

    serial_rx uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .tick         (tick),
        .rxd          (rxd),
        .cfg_wlen     (cfg_wlen),
        .cfg_par_en   (cfg_par_en),
        .cfg_par_even (cfg_par_even),
        .cfg_stop2    (cfg_stop2),
        .rx_data      (rx_data),
        .rx_perr      (rx_perr),
        .rx_ferr      (rx_ferr),
        .rx_brk       (rx_brk),
        .rx_valid     (rx_valid)
    );

    int checks   = 0;
    int failures = 0;
    bit finished = 0;

    initial clk = 1'b0;
    always #2 clk = ~clk;

    // tick generator: one clock in four, updated on the falling edge
    logic [1:0] div;
    initial begin
        div  = '0;
        tick = 1'b0;
    end
    always @(negedge clk) begin
        div  <= div + 2'd1;
        tick <= (div == 2'd3);
    end

    // strobe recorder
    logic [7:0] got_data [256];
    logic       got_perr [256];
    logic       got_ferr [256];
    logic       got_brk  [256];
    int         got_n = 0;

    always @(negedge clk) begin
        if (rst_n && rx_valid === 1'b1 && got_n < 256) begin
            got_data[got_n] = rx_data;
            got_perr[got_n] = rx_perr;
            got_ferr[got_n] = rx_ferr;
            got_brk[got_n]  = rx_brk;
            got_n           = got_n + 1;
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic wait_ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            while (tick !== 1'b1) @(posedge clk);
        end
    endtask

    task automatic hold(input bit v, input int n);
        @(negedge clk);
        rxd = v;
        wait_ticks(n);
    endtask

    function automatic int wbits(input logic [1:0] sel);
        return 5 + int'(sel);
    endfunction

    function automatic logic [7:0] wmask(input logic [1:0] sel);
        return 8'((9'd1 << wbits(sel)) - 9'd1);
    endfunction

    function automatic bit good_parity(input logic [7:0] d, input bit even);
        return even ? (^d) : ~(^d);
    endfunction

    task automatic set_cfg(input logic [1:0] wl, input bit pen, input bit even, input bit s2);
        @(negedge clk);
        cfg_wlen     = wl;
        cfg_par_en   = pen;
        cfg_par_even = even;
        cfg_stop2    = s2;
    endtask

    // start, data bits, optional parity, nstop high stop bits
    task automatic send_frame(input logic [7:0] d, input bit flip_par, input int nstop);
        hold(1'b0, 16);
        for (int i = 0; i < wbits(cfg_wlen); i++) hold(d[i], 16);
        if (cfg_par_en) hold(good_parity(d & wmask(cfg_wlen), cfg_par_even) ^ flip_par, 16);
        if (nstop > 0) hold(1'b1, 16 * nstop);
    endtask

    task automatic expect_char(input string req, input int idx, input logic [7:0] d,
                               input bit pe, input bit fe, input bit bk);
        check(got_data[idx] === d,  req, "data", int'(got_data[idx]), int'(d));
        check(got_perr[idx] === pe, req, "perr", int'(got_perr[idx]), int'(pe));
        check(got_ferr[idx] === fe, req, "ferr", int'(got_ferr[idx]), int'(fe));
        check(got_brk[idx]  === bk, req, "brk",  int'(got_brk[idx]),  int'(bk));
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        summary();
    end

    initial begin
        int base;
        int seed_dummy;
        rst_n        = 1'b0;
        rxd          = 1'b1;
        cfg_wlen     = 2'd3;
        cfg_par_en   = 1'b0;
        cfg_par_even = 1'b0;
        cfg_stop2    = 1'b0;
        seed_dummy   = int'($urandom(32'd2024));
        repeat (5) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        check(rx_valid === 1'b0, "R1", "valid", int'(rx_valid), 0);
        check(rx_data === 8'h00, "R1", "data", int'(rx_data), 0);
        check({rx_perr, rx_ferr, rx_brk} === 3'b000, "R1", "flags",
              int'({rx_perr, rx_ferr, rx_brk}), 0);
        hold(1'b1, 20);

        // R2: low for 8 ticks only, line high at the midpoint sample
        base = got_n;
        hold(1'b0, 8);
        hold(1'b1, 40);
        check(got_n == base, "R2", "glitch strobes", got_n - base, 0);

        // R3 R10: plain 8-bit frame
        set_cfg(2'd3, 1'b0, 1'b0, 1'b0);
        base = got_n;
        send_frame(8'hA5, 1'b0, 1);
        hold(1'b1, 8);
        check(got_n == base + 1, "R10", "strobes", got_n - base, 1);
        expect_char("R3", base, 8'hA5, 1'b0, 1'b0, 1'b0);

        // R3: 5-bit frame, upper bits zero
        set_cfg(2'd0, 1'b0, 1'b0, 1'b0);
        base = got_n;
        send_frame(8'hFF, 1'b0, 1);
        hold(1'b1, 8);
        check(got_n == base + 1, "R3", "strobes", got_n - base, 1);
        expect_char("R3", base, 8'h1F, 1'b0, 1'b0, 1'b0);

        // R4: even parity with a wrong parity bit, odd parity correct
        set_cfg(2'd2, 1'b1, 1'b1, 1'b0);
        base = got_n;
        send_frame(8'h35, 1'b1, 1);
        hold(1'b1, 8);
        expect_char("R4", base, 8'h35, 1'b1, 1'b0, 1'b0);
        set_cfg(2'd2, 1'b1, 1'b0, 1'b0);
        base = got_n;
        send_frame(8'h35, 1'b0, 1);
        hold(1'b1, 8);
        expect_char("R4", base, 8'h35, 1'b0, 1'b0, 1'b0);

        // R5: two stop bits configured, next frame right after one stop bit
        set_cfg(2'd3, 1'b0, 1'b0, 1'b1);
        base = got_n;
        send_frame(8'h81, 1'b0, 1);
        send_frame(8'h7E, 1'b0, 2);
        hold(1'b1, 8);
        check(got_n == base + 2, "R5", "strobes", got_n - base, 2);
        expect_char("R5", base,     8'h81, 1'b0, 1'b0, 1'b0);
        expect_char("R5", base + 1, 8'h7E, 1'b0, 1'b0, 1'b0);

        // R6: low stop bit becomes the next start bit
        set_cfg(2'd3, 1'b0, 1'b0, 1'b0);
        base = got_n;
        send_frame(8'h5A, 1'b0, 0);
        hold(1'b0, 16);
        for (int i = 0; i < 8; i++) hold(8'h3C >> i & 8'h01, 16);
        hold(1'b1, 24);
        check(got_n == base + 2, "R6", "strobes", got_n - base, 2);
        expect_char("R6", base,     8'h5A, 1'b0, 1'b1, 1'b0);
        expect_char("R6", base + 1, 8'h3C, 1'b0, 1'b0, 1'b0);

        // R8: 5N1 limit is 112 ticks; exactly 112 low ticks is not a break
        set_cfg(2'd0, 1'b0, 1'b0, 1'b0);
        base = got_n;
        hold(1'b0, 112);
        hold(1'b1, 40);
        check(got_n == base + 1, "R8", "strobes", got_n - base, 1);
        expect_char("R8", base, 8'h00, 1'b0, 1'b1, 1'b0);

        // R7: 113 low ticks is a break
        base = got_n;
        hold(1'b0, 113);
        hold(1'b1, 40);
        check(got_n == base + 1, "R7", "strobes", got_n - base, 1);
        expect_char("R7", base, 8'h00, 1'b0, 1'b1, 1'b1);

        // R7 R9: long break gives one character; recovery after high
        set_cfg(2'd3, 1'b1, 1'b0, 1'b1);
        base = got_n;
        hold(1'b0, 600);
        check(got_n == base + 1, "R9", "strobes during break", got_n - base, 1);
        expect_char("R7", base, 8'h00, 1'b0, 1'b1, 1'b1);
        hold(1'b1, 20);
        check(got_n == base + 1, "R9", "strobes after rise", got_n - base, 1);
        send_frame(8'hC3, 1'b0, 2);
        hold(1'b1, 8);
        check(got_n == base + 2, "R9", "strobes after recovery", got_n - base, 2);
        expect_char("R9", base + 1, 8'hC3, 1'b0, 1'b0, 1'b0);

        // R3 R4 R10: random formats and data, some parity flips
        for (int k = 0; k < 40; k++) begin
            logic [1:0] wl;
            bit         pen, even, s2, flip;
            logic [7:0] d;
            int         gap;
            wl   = 2'($urandom % 4);
            pen  = 1'($urandom % 2);
            even = 1'($urandom % 2);
            s2   = 1'($urandom % 2);
            flip = pen && ($urandom % 4 == 0);
            d    = 8'($urandom) & wmask(wl);
            gap  = 1 + int'($urandom % 20);
            set_cfg(wl, pen, even, s2);
            base = got_n;
            send_frame(d, flip, s2 ? 2 : 1);
            hold(1'b1, gap);
            check(got_n == base + 1, "R10", "random strobes", got_n - base, 1);
            expect_char("R4", base, d, flip, 1'b0, 1'b0);
        end

        summary();
    end

endmodule